// File: doc/BRIEF.md
# Serial Display-Register Loader

This block is a write-only I2C target that fills a 480-word display register RAM on an on-screen-display device. A bus master addresses the device, then sends a row byte and a column byte that select the first register. After that it sends any number of 16-bit words, each as two bytes with the high byte first. Each word is written to the current register, and the column then steps forward by one, so a whole row can be loaded in a single burst.

The block samples SCL and SDA with the system clock, finds START and STOP conditions, and pulls SDA low to acknowledge bytes. It drives a single-cycle RAM write port. Character cells, per-row attribute words and frame-control words each go to their own region of the RAM. A frame-control word that carries the clear flag starts a sweep that writes zero to every RAM entry.

Top module: `osd_i2c_regwr`

## Requirements
- R1: After reset, and until a START arrives, the block drives no write strobe and leaves SDA released (`sda_oe` low).
- R2: The first byte after a START is acknowledged only when it equals 0xBA, which is the 7-bit address 0x5D with the read/write bit at 0. Any other first byte, including the read request 0xBB, gets no acknowledge, and every later byte is ignored until the next START.
- R3: Only bits 3..0 of the row byte and bits 4..0 of the column byte are used. Their upper bits have no effect.
- R4: Every address and data byte accepted by the block is acknowledged. Each pair of data bytes forms one word, with the first byte in bits 15..8. For rows 0–14 and columns 0–29, the word is written at address row*30 + column.
- R5: After each completed word, the column rises by one. The column wraps from 31 to 0 and the row does not change.
- R6: A word sent to column 30 of a row from 0 to 14 holds that row's attributes and is written at address 453 + row.
- R7: Row 15, columns 0–2, are the frame-control words at addresses 450–452. Words sent to row 15 with a column of 3 or more, and words sent to column 31 of any row, are acknowledged but not written.
- R8: If a STOP arrives when only the high byte of a word has been received, that byte is discarded and no write takes place.
- R9: A word written at address 450 (frame control 0) with bit 6 set is written first. From the next cycle on, the block writes 0x0000 to addresses 0 through 479 in ascending order, one address per cycle.
- R10: While that clearing sweep runs, data bytes get no acknowledge and cause no write. Once the sweep ends, writes are accepted as normal.
- R11: A repeated START in the middle of a transfer begins a new address phase, and the row and column sent after it take effect.
- R12: Each word received over the bus produces exactly one write strobe, one clock cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low (acknowledge) |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 9 | RAM word address |
| wr_data | output | 16 | RAM write data |

## Verification
The bench sends all 256 possible first bytes and checks that only 0xBA is acknowledged. A loose address compare would answer other devices or reads. Every row gets a 32-word burst that crosses the row-attribute column and the dead column 31, using row and column bytes with junk in their upper bits. A mapping error would put cells, row attributes or frame words in the wrong place, or would write entries that should be dropped. Further tests send a lone high byte followed by STOP, a repeated START, and a burst that wraps from column 31 back to column 0. A design that gets these wrong writes a stray word, keeps stale addressing, or moves on to the next row. The clear test checks that all 480 zero writes follow straight after the frame word, and that a byte sent during the sweep is refused. A broken sweep would leave entries set or let a bus write land in memory that is still being cleared.

// File: rtl/osd_i2c_regwr.sv
module osd_i2c_regwr #(
  parameter int ROWS = 16,
  parameter int COLS = 30,
  parameter int FRAME_REGS = 3,
  parameter int ERASE_BIT = 6,
  parameter logic [6:0] DEV_ADDR = 7'h5D,
  localparam int DEPTH = ROWS * COLS,
  localparam int AW = $clog2(DEPTH),
  localparam int FRAME0 = (ROWS - 1) * COLS,
  localparam int RATTR_BASE = FRAME0 + FRAME_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK, S_SKIP} st_t;
  typedef enum logic [2:0] {K_DEV, K_ROW, K_COL, K_MSB, K_LSB} kind_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  kind_t      kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg, msb;
  logic [3:0] row;
  logic [4:0] col;
  logic       er_busy;
  logic [AW-1:0] er_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  wire scl_hi   = scl_q[1] & scl_q[2];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_hi & ~sda_q[1] & sda_q[2];
  wire stop_c   = scl_hi & sda_q[1] & ~sda_q[2];

  wire byte_done = (st == S_RX) && (bitcnt == 4'd8) && scl_fall;

  logic ack_ok;
  always_comb
    case (kind)
      K_DEV:        ack_ok = (shreg == {DEV_ADDR, 1'b0});
      K_ROW, K_COL: ack_ok = 1'b1;
      default:      ack_ok = !er_busy;
    endcase

  wire word_go = byte_done && (kind == K_LSB) && ack_ok;
  wire [15:0] word = {msb, shreg};

  logic          tgt_ok;
  logic [AW-1:0] tgt;
  always_comb begin
    tgt_ok = 1'b0;
    tgt    = AW'(32'(row) * COLS + 32'(col));
    if (32'(col) < COLS)
      tgt_ok = (32'(row) < ROWS - 1) || (32'(col) < FRAME_REGS);
    else if (32'(col) == COLS && 32'(row) < ROWS - 1) begin
      tgt_ok = 1'b1;
      tgt    = AW'(RATTR_BASE + 32'(row));
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      kind   <= K_DEV;
      bitcnt <= '0;
      shreg  <= '0;
      msb    <= '0;
      row    <= '0;
      col    <= '0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= S_RX;
      kind   <= K_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_q[1]};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (!ack_ok) st <= S_SKIP;
            else begin
              sda_oe <= 1'b1;
              st     <= S_ACK;
              case (kind)
                K_DEV: kind <= K_ROW;
                K_ROW: begin row <= shreg[3:0]; kind <= K_COL; end
                K_COL: begin col <= shreg[4:0]; kind <= K_MSB; end
                K_MSB: begin msb <= shreg; kind <= K_LSB; end
                default: begin col <= col + 5'd1; kind <= K_MSB; end
              endcase
            end
          end
        S_ACK:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_RX;
            bitcnt <= '0;
          end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      er_busy <= 1'b0;
      er_cnt  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (er_busy) begin
        wr_en   <= 1'b1;
        wr_addr <= er_cnt;
        wr_data <= '0;
        er_cnt  <= er_cnt + 1'b1;
        if (er_cnt == AW'(DEPTH - 1)) er_busy <= 1'b0;
      end else if (word_go && tgt_ok) begin
        wr_en   <= 1'b1;
        wr_addr <= tgt;
        wr_data <= word;
        if (tgt == AW'(FRAME0) && word[ERASE_BIT]) begin
          er_busy <= 1'b1;
          er_cnt  <= '0;
        end
      end
    end

endmodule

module osd_i2c_regwr_chk #(
  parameter int AW = 9,
  parameter int DEPTH = 480,
  parameter int FRAME0 = 450,
  parameter int ERASE_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [15:0]   wr_data
);

  assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < DEPTH));

  assert_ack_edges_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_in);

  assert_clear_follows_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(wr_addr) == FRAME0 && wr_data[ERASE_BIT]) |=> (wr_en && wr_addr == '0 && wr_data == 16'h0));

  assert_sweep_ascending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && wr_addr != '0) |-> (wr_addr == $past(wr_addr) + 1'b1));

  assert_sweep_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_data == 16'h0));

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(wr_en)) |=> (!wr_en || wr_addr == '0));

endmodule

bind osd_i2c_regwr osd_i2c_regwr_chk #(
  .AW(AW), .DEPTH(DEPTH), .FRAME0(FRAME0), .ERASE_BIT(ERASE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/osd_i2c_regwr_test.sv
module osd_i2c_regwr_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 5;
  localparam int LOGN = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_en;
  logic [8:0] wr_addr;
  logic [15:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0, n = 0;
  bit done = 0;
  int log_a [LOGN];
  int log_d [LOGN];

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_i2c_regwr uut (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
                     .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk)
    if (wr_en && n < LOGN) begin
      log_a[n] = int'(wr_addr);
      log_d[n] = int'(wr_data);
      n = n + 1;
    end

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(HP);
    scl = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl = 1'b0; tick(HP);
  endtask

  task automatic i2c_stop;
    tick(2); sda_m = 1'b0; tick(HP);
    scl = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(2); sda_m = b[i]; tick(HP);
      scl = 1'b1; tick(HP);
      scl = 1'b0;
    end
    tick(2); sda_m = 1'b1; tick(HP);
    scl = 1'b1; tick(HP/2);
    ack = ~sda_line;
    tick(HP - HP/2);
    scl = 1'b0;
  endtask

  function automatic int exp_addr(int r, int c);
    if (c < 30) return (r < 15 || c < 3) ? r*30 + c : -1;
    if (c == 30 && r < 15) return 453 + r;
    return -1;
  endfunction

  function automatic int wdata(int r, int k);
    return ((r << 12) ^ (k * 16'h0519) ^ 16'h00A5) & 16'hFFBF;
  endfunction

  task automatic burst(input int r, input int c0, input int cnt, input string req);
    bit a;
    int base, idx, c;
    base = n;
    i2c_start;
    send(8'hBA, a); chk(a, "R2", a, 1);
    send(8'hA0 | 8'(r), a); chk(a, "R3", a, 1);
    send(8'hE0 | 8'(c0), a); chk(a, "R3", a, 1);
    for (int k = 0; k < cnt; k++) begin
      send(8'(wdata(r, k) >> 8), a); chk(a, "R4", a, 1);
      send(8'(wdata(r, k)), a); chk(a, "R4", a, 1);
    end
    i2c_stop;
    tick(4);
    idx = base;
    for (int k = 0; k < cnt; k++) begin
      c = (c0 + k) % 32;
      if (exp_addr(r, c) >= 0) begin
        chk(log_a[idx] == exp_addr(r, c), req, log_a[idx], exp_addr(r, c));
        chk(log_d[idx] == wdata(r, k), "R4", log_d[idx], wdata(r, k));
        idx++;
      end
    end
    chk(n == idx, "R7 R12 write count", n - base, idx - base);
  endtask

  initial begin
    bit a;
    int base;
    tick(5); rst_n = 1'b1;
    // R1: idle after reset
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (sda_oe || wr_en) chk(0, "R1", {sda_oe, wr_en}, 0);
    end
    chk(n == 0 && !sda_oe, "R1 reset", n, 0);

    // R2: every possible first byte
    for (int b = 0; b < 256; b++) begin
      i2c_start;
      send(8'(b), a);
      chk(a == (b == 8'hBA), "R2 address byte", a, b == 8'hBA);
      i2c_stop;
    end
    // R2: bytes after a refused address are ignored
    base = n;
    i2c_start;
    send(8'hBB, a); chk(!a, "R2 read request", a, 0);
    send(8'h01, a); chk(!a, "R2 ignored row", a, 0);
    send(8'h00, a); chk(!a, "R2 ignored col", a, 0);
    send(8'h12, a); send(8'h34, a); chk(!a, "R2 ignored data", a, 0);
    i2c_stop; tick(4);
    chk(n == base, "R2 no write", n - base, 0);

    // R3 R4 R6 R7: every row, 32-word burst from column 0
    for (int r = 0; r < 16; r++) burst(r, 0, 32, "R4 R6 R7 address");
    // R5: wrap from column 31 to 0 in the same row
    burst(4, 30, 4, "R5 wrap");

    // R8: lone high byte then STOP
    base = n;
    i2c_start;
    send(8'hBA, a); send(8'h02, a); send(8'h03, a);
    send(8'h55, a); chk(a, "R8 msb ack", a, 1);
    i2c_stop; tick(20);
    chk(n == base, "R8 partial word dropped", n - base, 0);

    // R11: repeated START re-addresses
    base = n;
    i2c_start;
    send(8'hBA, a); send(8'h02, a); send(8'h05, a);
    i2c_start;
    send(8'hBA, a); send(8'h03, a); send(8'h07, a);
    send(8'hBE, a); send(8'hEF, a);
    i2c_stop; tick(4);
    chk(n == base + 1, "R11 count", n - base, 1);
    chk(log_a[base] == 97, "R11 addr", log_a[base], 97);
    chk(log_d[base] == 16'hBEEF, "R11 data", log_d[base], 16'hBEEF);

    // R9 R10: clear via frame control 0
    base = n;
    i2c_start;
    send(8'hBA, a); send(8'h0F, a); send(8'h00, a);
    send(8'h00, a); send(8'h40, a); chk(a, "R9 frame word ack", a, 1);
    send(8'h12, a); chk(!a, "R10 nack while clearing", a, 0);
    i2c_stop; tick(600);
    chk(n == base + 481, "R10 write count", n - base, 481);
    chk(log_a[base] == 450 && log_d[base] == 16'h0040, "R9 frame word", log_a[base], 450);
    for (int i = 0; i < 480; i++)
      if (log_a[base+1+i] != i || log_d[base+1+i] != 0)
        chk(0, "R9 sweep entry", log_a[base+1+i], i);
    chk(1, "R9 sweep", 0, 0);
    // R10: normal writes resume
    burst(1, 1, 1, "R10 resume");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule